// File: doc/BRIEF.md
# Progressive-to-Interlaced Line Dropper

This block sits in a pixel stream and turns each progressive frame into one interlaced field by discarding every other line on the fly. It stores no lines. Input and output are ready/valid packet streams with start and end markers, carrying one pixel per beat. Field parity flips from one progressive frame to the next. Parity restarts at a configured field when the frame size changes, and it can also be forced by the interlace nibble of an incoming control packet. When the frame height is odd, a top field gets one line more than a bottom field.

The low nibble of the first beat of a packet gives the packet type. Control packets are parsed for width, height and interlace nibble. The block then sends out a rewritten control packet that describes the field it will produce. Input that is already interlaced is either forwarded or silently swallowed, chosen by a build-time parameter. A three-register port offers a run enable, a progressive bypass and a busy flag.

Top module: `prog_to_field`

## Requirements
- R1: The low nibble of the first beat (the beat carrying in_sop) gives the packet type: 0 is video, 15 is control. Any other type is forwarded beat for beat, unchanged.
- R2: F0 keeps lines 0, 2, 4… and F1 keeps lines 1, 3, 5…, where a line is `width` pixel beats after the video header. The video header is always forwarded. A dropped beat is taken with in_ready=1 and out_valid=0. out_eop is raised on the last pixel of the last kept line, and any remaining input beats are consumed silently.
- R3: Each progressive video frame produces one field, and the parity of consecutive fields alternates.
- R4: A control packet has a header beat followed by nine body beats. Each body beat carries one nibble in bits [3:0]: four nibbles of width (most significant first), four nibbles of height, then the interlace nibble. The input control packet is consumed completely before an output control packet is sent. The output packet has the same layout and width. Its height is ceil(H/2) for F0 or floor(H/2) for F1, and its interlace nibble is 1000 for F0 or 1100 for F1.
- R5: After reset the frame size is MAX_W by MAX_H. After reset, and after any control packet whose width or height differs from the current size, the next field is INIT_FIELD (0 = F0, 1 = F1).
- R6: With OVERRIDE=1, a progressive interlace nibble of 0000 forces the next field to F0 and 0001 forces it to F1. This takes priority over the restart in R5. Other progressive nibbles leave the alternation alone.
- R7: An interlace nibble with bit 3 set marks the input as interlaced. With PASS_IL=1, the control packet and the video that follows are forwarded unchanged. With PASS_IL=0, both are consumed and produce no output.
- R8: Register 2 bit 0 is the bypass bit. When it is set, progressive video and control packets pass unmodified, and the bit is sampled only at the start of a packet.
- R9: Register 0 bit 0 is the run bit, and its reset value is 1. While it is 0, no new packet is accepted: in_ready=0 and out_valid=0 at packet boundaries.
- R10: Register 1 bit 0 reads 1 while a packet is in progress and 0 when idle. Writes to register 1 have no effect. Bits [7:1] of every register read as 0.
- R11: out_ready low stalls in_ready only while a beat is being forwarded. While an output control packet waits on out_ready, out_valid and out_data hold steady and in_ready stays 0.
- R12: Reset is asynchronous and active high. After reset out_valid=0, the run bit is 1 and the bypass bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| in_data | input | DW | Input beat data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts the input beat |
| in_sop | input | 1 | First beat of an input packet |
| in_eop | input | 1 | Last beat of an input packet |
| out_data | output | DW | Output beat data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
A wrong parity register shows up in the first field after the fault. That field carries the wrong lines, and when the height is odd it also carries the wrong number of lines. The next output control packet carries the wrong height and nibble as well. A bad line or pixel counter moves out_eop off the last kept pixel within one field, so either an extra beat reaches the scoreboard or an expected beat never arrives. A stuck state machine is seen at the next packet as a stalled in_ready, an unexpected beat, or a busy flag that never returns to 0.

// File: rtl/p2f_pkg.sv
package p2f_pkg;
    localparam int DIM_BITS  = 16;
    localparam int BODY_NIBS = 9;

    localparam logic [3:0] TYPE_VIDEO = 4'd0;
    localparam logic [3:0] TYPE_CTRL  = 4'd15;
    localparam logic [3:0] NIB_TOP    = 4'b1000;
    localparam logic [3:0] NIB_BOT    = 4'b1100;

    typedef enum logic [2:0] {
        S_IDLE, S_VID, S_TAIL, S_CTL_IN, S_CTL_OUT, S_FWD, S_DROP
    } st_e;

    typedef struct packed {
        st_e                             st;
        logic                            fld;
        logic                            nxt_f;
        logic                            byp;
        logic [DIM_BITS-1:0]             cur_w;
        logic [DIM_BITS-1:0]             cur_h;
        logic                            cur_il;
        logic [BODY_NIBS-1:0][3:0]       nib;
        logic [3:0]                      cidx;
        logic [3:0]                      ocnt;
        logic [DIM_BITS-1:0]             em_w;
        logic [DIM_BITS-1:0]             em_h;
        logic [3:0]                      em_nib;
        logic [DIM_BITS-1:0]             last_line;
    } core_t;

    function automatic logic [DIM_BITS-1:0] field_lines(input logic [DIM_BITS-1:0] h,
                                                        input logic f);
        logic [DIM_BITS:0] t;
        t = {1'b0, h} + {{DIM_BITS{1'b0}}, ~f};
        return t[DIM_BITS:1];
    endfunction
endpackage

// File: rtl/p2f_regs.sv
module p2f_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] addr,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       busy,
    output logic       go,
    output logic       bypass,
    output logic [7:0] rdata
);
    typedef struct packed {
        logic go;
        logic byp;
    } regs_t;

    regs_t r_q, r_d;
    logic  unused_hi;
    assign unused_hi = ^wdata[7:1];

    always_comb begin
        r_d = r_q;
        if (wr && addr == 2'd0) r_d.go  = wdata[0];
        if (wr && addr == 2'd2) r_d.byp = wdata[0];
        case (addr)
            2'd0:    rdata = {7'b0, r_q.go};
            2'd1:    rdata = {7'b0, busy};
            2'd2:    rdata = {7'b0, r_q.byp};
            default: rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '{go: 1'b1, byp: 1'b0};
        else     r_q <= r_d;
    end

    assign go     = r_q.go;
    assign bypass = r_q.byp;

    AST_GO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 2'd0) |=> (go == $past(wdata[0]))); // R9
    AST_BYP_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == 2'd2) |=> $stable(bypass)); // R8
endmodule

// File: rtl/p2f_line_track.sv
module p2f_line_track #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] width,
    output logic [CW-1:0] pix,
    output logic [CW-1:0] line
);
    typedef struct packed {
        logic [CW-1:0] pix;
        logic [CW-1:0] line;
    } cnt_t;

    cnt_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (clear) begin
            c_d = '0;
        end else if (step) begin
            if (c_q.pix == width - CW'(1)) begin
                c_d.pix  = '0;
                c_d.line = c_q.line + CW'(1);
            end else begin
                c_d.pix = c_q.pix + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign pix  = c_q.pix;
    assign line = c_q.line;

    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $fell(clear) |-> (pix == '0 && line == '0)); // R2
    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!clear && width != '0) |-> (pix < width)); // R2
endmodule

// File: rtl/p2f_ctl_gen.sv
module p2f_ctl_gen
    import p2f_pkg::*;
(
    input  logic [3:0]          idx,
    input  logic [DIM_BITS-1:0] w,
    input  logic [DIM_BITS-1:0] h,
    input  logic [3:0]          nib,
    output logic [3:0]          nib_o,
    output logic                last
);
    always_comb begin
        case (idx)
            4'd0:    nib_o = TYPE_CTRL;
            4'd1:    nib_o = w[15:12];
            4'd2:    nib_o = w[11:8];
            4'd3:    nib_o = w[7:4];
            4'd4:    nib_o = w[3:0];
            4'd5:    nib_o = h[15:12];
            4'd6:    nib_o = h[11:8];
            4'd7:    nib_o = h[7:4];
            4'd8:    nib_o = h[3:0];
            default: nib_o = nib;
        endcase
        last = (idx == 4'(BODY_NIBS));
    end
endmodule

// File: rtl/prog_to_field.sv
module prog_to_field
    import p2f_pkg::*;
#(
    parameter int DW         = 8,
    parameter int MAX_W      = 640,
    parameter int MAX_H      = 480,
    parameter bit INIT_FIELD = 1'b0,
    parameter bit OVERRIDE   = 1'b0,
    parameter bit PASS_IL    = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sop,
    output logic          out_eop,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata
);
    localparam logic [DIM_BITS-1:0] RST_W = DIM_BITS'(MAX_W);
    localparam logic [DIM_BITS-1:0] RST_H = DIM_BITS'(MAX_H);
    localparam logic [3:0]          LAST_BODY = 4'(BODY_NIBS);

    core_t q, d;
    logic go, bypass, busy;
    logic step, clear;
    logic [DIM_BITS-1:0] pix, line;
    logic [3:0] gen_nib;
    logic gen_last;
    logic hs, keep, last_kept;
    logic [3:0] in_nib;
    logic [DIM_BITS-1:0] w_new, h_new, lline;
    logic [3:0] il_new;
    logic prog_new, chg;

    assign busy  = (q.st != S_IDLE);
    assign clear = (q.st != S_VID);

    p2f_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .busy(busy), .go(go), .bypass(bypass), .rdata(reg_rdata)
    );

    p2f_line_track #(.CW(DIM_BITS)) u_track (
        .clk(clk), .rst(rst), .clear(clear), .step(step), .width(q.cur_w),
        .pix(pix), .line(line)
    );

    p2f_ctl_gen u_gen (
        .idx(q.ocnt), .w(q.em_w), .h(q.em_h), .nib(q.em_nib),
        .nib_o(gen_nib), .last(gen_last)
    );

    assign in_nib = in_data[3:0];

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_sop   = in_sop;
        out_eop   = in_eop;
        step      = 1'b0;
        hs        = 1'b0;
        keep      = (line[0] == q.fld);
        last_kept = keep && (line == q.last_line) && (pix == q.cur_w - DIM_BITS'(1));
        w_new     = '0;
        h_new     = '0;
        il_new    = '0;
        prog_new  = 1'b0;
        chg       = 1'b0;
        lline     = q.cur_h - DIM_BITS'(1);
        if (lline[0] != q.nxt_f) lline = lline - DIM_BITS'(1);

        case (q.st)
            S_IDLE: begin
                if (go) begin
                    if (!in_sop) begin
                        in_ready = 1'b1;
                    end else if (in_nib == TYPE_CTRL) begin
                        in_ready = 1'b1;
                        hs = in_valid;
                        if (hs) begin
                            d.byp  = bypass;
                            d.cidx = '0;
                            if (!in_eop) d.st = S_CTL_IN;
                        end
                    end else if (in_nib == TYPE_VIDEO && q.cur_il && !PASS_IL) begin
                        in_ready = 1'b1;
                        hs = in_valid;
                        if (hs && !in_eop) d.st = S_DROP;
                    end else if (in_nib == TYPE_VIDEO && !q.cur_il && !bypass) begin
                        in_ready  = out_ready;
                        out_valid = in_valid;
                        hs = in_valid && out_ready;
                        if (hs) begin
                            d.fld       = q.nxt_f;
                            d.nxt_f     = ~q.nxt_f;
                            d.last_line = lline;
                            if (!in_eop) d.st = S_VID;
                        end
                    end else begin
                        in_ready  = out_ready;
                        out_valid = in_valid;
                        hs = in_valid && out_ready;
                        if (hs && !in_eop) d.st = S_FWD;
                    end
                end
            end
            S_FWD: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (in_valid && out_ready && in_eop) d.st = S_IDLE;
            end
            S_DROP, S_TAIL: begin
                in_ready = 1'b1;
                if (in_valid && in_eop) d.st = S_IDLE;
            end
            S_VID: begin
                in_ready  = keep ? out_ready : 1'b1;
                out_valid = in_valid && keep;
                out_sop   = 1'b0;
                out_eop   = in_eop || last_kept;
                hs        = in_valid && in_ready;
                step      = hs;
                if (hs) begin
                    if (in_eop)         d.st = S_IDLE;
                    else if (last_kept) d.st = S_TAIL;
                end
            end
            S_CTL_IN: begin
                in_ready = 1'b1;
                hs = in_valid;
                if (hs) begin
                    if (q.cidx < LAST_BODY) begin
                        d.nib[q.cidx] = in_nib;
                        d.cidx = q.cidx + 4'd1;
                    end
                    if (in_eop) begin
                        w_new    = {d.nib[0], d.nib[1], d.nib[2], d.nib[3]};
                        h_new    = {d.nib[4], d.nib[5], d.nib[6], d.nib[7]};
                        il_new   = d.nib[8];
                        prog_new = !il_new[3];
                        chg      = (w_new != q.cur_w) || (h_new != q.cur_h);
                        d.cur_w  = w_new;
                        d.cur_h  = h_new;
                        d.cur_il = !prog_new;
                        if (chg) d.nxt_f = INIT_FIELD;
                        if (OVERRIDE && il_new == 4'b0000) d.nxt_f = 1'b0;
                        if (OVERRIDE && il_new == 4'b0001) d.nxt_f = 1'b1;
                        d.em_w = w_new;
                        d.ocnt = '0;
                        if (!prog_new) begin
                            d.em_h   = h_new;
                            d.em_nib = il_new;
                            d.st     = PASS_IL ? S_CTL_OUT : S_IDLE;
                        end else if (q.byp) begin
                            d.em_h   = h_new;
                            d.em_nib = il_new;
                            d.st     = S_CTL_OUT;
                        end else begin
                            d.em_h   = field_lines(h_new, d.nxt_f);
                            d.em_nib = d.nxt_f ? NIB_BOT : NIB_TOP;
                            d.st     = S_CTL_OUT;
                        end
                    end
                end
            end
            S_CTL_OUT: begin
                out_valid     = 1'b1;
                out_data      = '0;
                out_data[3:0] = gen_nib;
                out_sop       = (q.ocnt == 4'd0);
                out_eop       = gen_last;
                if (out_ready) begin
                    d.ocnt = q.ocnt + 4'd1;
                    if (gen_last) d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.nxt_f  <= INIT_FIELD;
            q.cur_w  <= RST_W;
            q.cur_h  <= RST_H;
        end else begin
            q <= d;
        end
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_CTL_OUT && !out_ready) |=> (out_valid && $stable(out_data))); // R11
    AST_CTL_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_CTL_OUT) |-> !in_ready); // R4
    AST_SILENT_DROP: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_DROP || q.st == S_TAIL) |-> (!out_valid && in_ready)); // R2
    AST_GO_STALL: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_IDLE && !go) |-> (!in_ready && !out_valid)); // R9
    AST_EOP_ENDS_FIELD: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_VID && out_valid && out_ready && out_eop) |=> (q.st != S_VID)); // R2
    AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (rst)
        ($past(q.st) == S_IDLE && q.st == S_VID) |-> (q.nxt_f != q.fld)); // R3
endmodule

// File: tb/sim_prog_to_field.sv
`timescale 1ns/100ps
module sim_prog_to_field;
    localparam int DW = 8;
    localparam int MW = 4;
    localparam int MH = 5;
    localparam bit INIT = 1'b1;

    logic clk = 1'b0, rst = 1'b1;
    logic [DW-1:0] in_data = '0, out_data;
    logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0;
    logic out_valid, out_ready, out_sop, out_eop;
    logic [1:0] reg_addr = 0;
    logic reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;

    always #2 clk = ~clk;

    prog_to_field #(.DW(DW), .MAX_W(MW), .MAX_H(MH), .INIT_FIELD(INIT),
                    .OVERRIDE(1'b1), .PASS_IL(1'b0)) u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    int errs = 0, checks = 0;
    logic [DW+1:0] qx[$];
    string qt[$];
    int mw = MW, mh = MH;
    bit mf = INIT, mil = 0, mbyp = 0;
    bit hold = 0, bp = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #0.5 out_ready = hold ? 1'b0 : (bp ? (cyc % 3 != 0) : 1'b1);
    end
    initial out_ready = 1'b1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (qx.size() == 0) begin
                chk(0, "R1", "unexpected output beat", int'({out_sop, out_eop, out_data}), 0);
            end else begin
                logic [DW+1:0] e;
                string t;
                e = qx.pop_front();
                t = qt.pop_front();
                chk({out_sop, out_eop, out_data} == e, t, "output beat",
                    int'({out_sop, out_eop, out_data}), int'(e));
            end
        end
    end

    task automatic exp_beat(input logic [DW-1:0] dd, input bit s, input bit e, input string t);
        qx.push_back({s, e, dd});
        qt.push_back(t);
    endtask

    task automatic drive(input logic [DW-1:0] dd, input bit s, input bit e);
        in_data = dd; in_sop = s; in_eop = e; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #0.5;
        in_valid = 1'b0; in_sop = 0; in_eop = 0;
    endtask

    function automatic logic [3:0] ctl_nib(input int i, input int w, input int h, input logic [3:0] n);
        if (i == 0) return 4'd15;
        if (i <= 4) return 4'((w >> (4 * (4 - i))) & 15);
        if (i <= 8) return 4'((h >> (4 * (8 - i))) & 15);
        return n;
    endfunction

    task automatic exp_ctl(input int w, input int h, input logic [3:0] n, input string t);
        for (int i = 0; i < 10; i++) exp_beat(DW'(ctl_nib(i, w, h, n)), i == 0, i == 9, t);
    endtask

    task automatic send_ctl(input int w, input int h, input logic [3:0] n, input string t);
        bit prog, chg;
        prog = !n[3];
        chg = (w != mw) || (h != mh);
        mw = w; mh = h; mil = !prog;
        if (chg) mf = INIT;
        if (n == 4'b0000) mf = 0;
        if (n == 4'b0001) mf = 1;
        if (prog) begin
            if (mbyp) exp_ctl(w, h, n, t);
            else exp_ctl(w, mf ? h / 2 : (h + 1) / 2, mf ? 4'b1100 : 4'b1000, t);
        end
        for (int i = 0; i < 10; i++) drive(DW'(ctl_nib(i, w, h, n)), i == 0, i == 9);
    endtask

    task automatic send_vid(input string t);
        bit f;
        int lastk;
        f = mf;
        lastk = ((mh - 1) % 2 == int'(f)) ? mh - 1 : mh - 2;
        if (!mil) begin
            exp_beat(8'hA0, 1, 0, t);
            if (!mbyp) mf = ~mf;
            for (int l = 0; l < mh; l++)
                for (int p = 0; p < mw; p++) begin
                    if (mbyp)
                        exp_beat(DW'(l * 16 + p), 0, (l == mh - 1) && (p == mw - 1), t);
                    else if (l % 2 == int'(f))
                        exp_beat(DW'(l * 16 + p), 0, (l == lastk) && (p == mw - 1), t);
                end
        end
        drive(8'hA0, 1, 0);
        for (int l = 0; l < mh; l++)
            for (int p = 0; p < mw; p++)
                drive(DW'(l * 16 + p), 0, (l == mh - 1) && (p == mw - 1));
    endtask

    task automatic drain(input string t);
        for (int i = 0; i < 300 && qx.size() != 0; i++) @(posedge clk);
        #0.5;
        chk(qx.size() == 0, t, "expected beats left undelivered", qx.size(), 0);
        while (qx.size() != 0) begin
            void'(qx.pop_front());
            void'(qt.pop_front());
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1;
        @(posedge clk); #0.5;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; #0.2;
        v = reg_rdata;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R12", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1, "R12", "in_ready idle after reset", in_ready, 1);
        rd(0, v); chk(v == 8'h01, "R12", "run bit reset value", v, 1);
        rd(2, v); chk(v == 8'h00, "R12", "bypass reset value", v, 0);
        rd(1, v); chk(v == 8'h00, "R10", "status idle", v, 0);
        @(posedge clk); #0.5;

        send_vid("R5 default size initial F1"); drain("R5");
        send_vid("R3 alternate to F0 odd height"); drain("R3");
        send_ctl(6, 4, 4'b0010, "R4 rewritten control after size change"); drain("R4");
        send_vid("R5 restart at F1"); drain("R5");
        send_vid("R2 F0 with dropped tail line"); drain("R2");
        send_ctl(6, 4, 4'b0000, "R6 override to F0"); drain("R6");
        send_vid("R6 forced F0 field"); drain("R6");
        send_ctl(6, 4, 4'b0011, "R6 other nibble keeps alternation"); drain("R6");
        send_vid("R6 F1 by alternation"); drain("R6");
        send_ctl(5, 3, 4'b0000, "R6 override beats restart"); drain("R6");
        send_vid("R6 F0 on 5x3"); drain("R6");

        exp_beat(8'h35, 1, 0, "R1 other packet"); drive(8'h35, 1, 0);
        rd(1, v); chk(v == 8'h01, "R10", "status busy mid packet", v, 1);
        exp_beat(8'h77, 0, 0, "R1 other packet"); drive(8'h77, 0, 0);
        exp_beat(8'h0F, 0, 1, "R1 other packet"); drive(8'h0F, 0, 1);
        drain("R1");
        rd(1, v); chk(v == 8'h00, "R10", "status back to idle", v, 0);
        wr(1, 8'h01);
        rd(1, v); chk(v == 8'h00, "R10", "write to status ignored", v, 0);

        bp = 1;
        send_vid("R11 backpressured field"); drain("R11");
        bp = 0;

        hold = 1;
        @(posedge clk); #0.5;
        send_ctl(6, 4, 4'b0010, "R11 held control output");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1 && in_ready == 0, "R11", "control output waits",
            {out_valid, in_ready}, 2'b10);
        chk(out_data == 8'h0F && out_sop == 1, "R11", "held header beat", out_data, 8'h0F);
        hold = 0;
        drain("R11");
        send_vid("R5 after size change"); drain("R5");

        wr(2, 8'h01); mbyp = 1;
        rd(2, v); chk(v == 8'h01, "R8", "bypass readback", v, 1);
        send_ctl(6, 4, 4'b0010, "R8 control unchanged in bypass"); drain("R8");
        send_vid("R8 full frame in bypass"); drain("R8");
        wr(2, 8'h00); mbyp = 0;

        send_ctl(6, 4, 4'b1000, "R7 interlaced control discarded"); drain("R7");
        send_vid("R7 interlaced field discarded"); drain("R7");
        send_ctl(6, 4, 4'b0010, "R7 back to progressive"); drain("R7");
        send_vid("R3 alternation resumes"); drain("R3");

        wr(0, 8'h00);
        in_data = 8'hA0; in_sop = 1; in_valid = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 0 && out_valid == 0, "R9", "run bit low stalls boundary",
            {in_ready, out_valid}, 0);
        @(posedge clk); #0.5;
        in_valid = 0; in_sop = 0;
        wr(0, 8'h01);
        send_vid("R9 resumes after run bit"); drain("R9");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule